// File: doc/BRIEF.md
# Oscillator Period Trim Search Controller

This block steers a digitally controlled oscillator onto a target period by binary search. It owns two delay-control words, a 10-bit coarse word and a 5-bit fine word, and treats them as one 15-bit trial code with the coarse word in the upper bits. An external comparator looks at the oscillator edge and a reference edge and reports whether the oscillator arrived late, meaning it is too slow. A larger code adds delay. Each trial bit is set first, left alone for one settling cycle so the current-steered delay can stabilise, and then kept or cleared on the next cycle from the comparator's answer.

The search starts on a rising enable. Once the last fine bit has been resolved the block raises a done flag and freezes both words. From then on the comparator input is ignored, so the reference clock can be turned off. An 8-bit current trim word comes in, is sampled while the block is idle and is held steady on its output for the whole search and afterwards. Dropping enable at any time abandons the search, clears done and parks both words at mid-scale.

Top module: `osc_sar_cal`

## Requirements
- R1: After reset, and one cycle after any edge at which enable is low, done_o is 0, coarse_o is 512 and fine_o is 16 (each word at mid-scale).
- R2: The combined code is {coarse_o, fine_o}, and its bit 14 is the coarse MSB. On the edge that samples enable high in idle, the code becomes 0x4000, so only the top trial bit is set. Each later trial bit is set to 1 before it is judged, going from bit 14 down to bit 0.
- R3: Evaluation edges come every second cycle. During a search the code never changes on two consecutive edges.
- R4: On an evaluation edge, slow_i = 1 (the oscillator edge is late) clears the bit under trial and slow_i = 0 keeps it.
- R5: If the period rises monotonically with the code, the final code is the largest code whose period does not exceed the target. If no code meets the target, the final code is 0.
- R6: Counting the edge that samples enable high in idle as edge 1, done_o is first high after edge 31.
- R7: While done_o and enable are high, coarse_o and fine_o hold their values whatever slow_i does.
- R8: Lowering enable returns the block to idle within one edge. Raising enable again starts a complete new search.
- R9: While idle, trim_o takes the trim_i value one edge later. Outside idle, trim_o does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | High runs or holds a calibration; low returns to idle |
| slow_i | input | 1 | Comparator decision: 1 when the oscillator edge lags the reference |
| trim_i | input | 8 | Current-source trim word |
| coarse_o | output | 10 | Coarse delay control word |
| fine_o | output | 5 | Fine delay control word |
| trim_o | output | 8 | Trim word held for the current source |
| done_o | output | 1 | Calibration complete and code frozen |

## Verification
The checker tests on every cycle the local rules of the search. It confirms that the evaluation edges alternate with settling edges and that the code stays still outside them. It checks that each decision lands on the bit that was under trial, that a search always starts from the single top bit, and that done appears only after the bit-0 decision. It also checks the mid-scale park when enable is low, the frozen code after done, and the trim hold. Only the bench scenarios show the global results. These are that the search lands on the largest code meeting the target for a monotonic period model, including the all-zero and all-ones extremes, that done rises on exactly the 31st edge, and that a search abandoned midway and then restarted reaches the same answer.

// File: rtl/osc_cal_pkg.sv
package osc_cal_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_EVAL   = 2'd2,
    PH_DONE   = 2'd3
  } cal_phase_e;

  // single set bit at a position (codes up to 32 bits)
  function automatic logic [31:0] one_hot32(input logic [31:0] pos);
    return 32'd1 << pos;
  endfunction

  // outcome of judging the trial bit: a late edge removes it
  function automatic logic [31:0] resolve_bit(input logic [31:0] code,
                                              input logic [31:0] pos,
                                              input logic        too_slow);
    return too_slow ? (code & ~one_hot32(pos)) : code;
  endfunction

  // arm the next lower trial bit, if any remains
  function automatic logic [31:0] next_trial(input logic [31:0] code,
                                             input logic [31:0] pos);
    return (pos == 32'd0) ? code : (code | one_hot32(pos - 32'd1));
  endfunction

  // both words at mid-scale, coarse word above fine word
  function automatic logic [31:0] mid_pair(input logic [31:0] cw,
                                           input logic [31:0] fw);
    return (one_hot32(cw - 32'd1) << fw) | one_hot32(fw - 32'd1);
  endfunction

endpackage

// File: rtl/osc_cal_seq.sv
module osc_cal_seq
  import osc_cal_pkg::*;
#(
  parameter int CODE_W = 15,
  localparam int IDX_W = $clog2(CODE_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  output cal_phase_e       phase_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             start_evt_o,
  output logic             eval_evt_o
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(CODE_W - 1);

  cal_phase_e       phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  assign start_evt_o = enable && (phase_q == PH_IDLE);
  assign eval_evt_o  = enable && (phase_q == PH_EVAL);

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    if (!enable) begin
      phase_d = PH_IDLE;
      idx_d   = TOP_IDX;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          phase_d = PH_SETTLE;
          idx_d   = TOP_IDX;
        end
        PH_SETTLE: phase_d = PH_EVAL;
        PH_EVAL: begin
          if (idx_q == '0) begin
            phase_d = PH_DONE;
          end else begin
            phase_d = PH_SETTLE;
            idx_d   = idx_q - 1'b1;
          end
        end
        default: phase_d = PH_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= TOP_IDX;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
    end
  end

  assign phase_o = phase_q;
  assign idx_o   = idx_q;

endmodule

// File: rtl/osc_cal_sar.sv
module osc_cal_sar
  import osc_cal_pkg::*;
#(
  parameter int COARSE_W = 10,
  parameter int FINE_W   = 5,
  localparam int CODE_W  = COARSE_W + FINE_W,
  localparam int IDX_W   = $clog2(CODE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              start_evt,
  input  logic              eval_evt,
  input  logic [IDX_W-1:0]  idx,
  input  logic              slow_i,
  output logic [CODE_W-1:0] code_o
);

  localparam logic [CODE_W-1:0] MID_CODE =
    CODE_W'(mid_pair(32'(COARSE_W), 32'(FINE_W)));
  localparam logic [CODE_W-1:0] FIRST_TRIAL =
    CODE_W'(one_hot32(32'(CODE_W - 1)));

  logic [CODE_W-1:0] code_q;
  logic [31:0]       judged;

  assign judged = resolve_bit(32'(code_q), 32'(idx), slow_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= MID_CODE;
    end else if (!enable) begin
      code_q <= MID_CODE;
    end else if (start_evt) begin
      code_q <= FIRST_TRIAL;
    end else if (eval_evt) begin
      code_q <= CODE_W'(next_trial(judged, 32'(idx)));
    end
  end

  assign code_o = code_q;

endmodule

// File: rtl/osc_cal_trim_hold.sv
module osc_cal_trim_hold #(
  parameter int TRIM_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [TRIM_W-1:0] trim_i,
  output logic [TRIM_W-1:0] trim_o
);

  logic [TRIM_W-1:0] trim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trim_q <= '0;
    end else if (capture) begin
      trim_q <= trim_i;
    end
  end

  assign trim_o = trim_q;

endmodule

// File: rtl/osc_sar_cal.sv
module osc_sar_cal
  import osc_cal_pkg::*;
#(
  parameter int COARSE_W = 10,
  parameter int FINE_W   = 5,
  parameter int TRIM_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                slow_i,
  input  logic [TRIM_W-1:0]   trim_i,
  output logic [COARSE_W-1:0] coarse_o,
  output logic [FINE_W-1:0]   fine_o,
  output logic [TRIM_W-1:0]   trim_o,
  output logic                done_o
);

  localparam int CODE_W = COARSE_W + FINE_W;
  localparam int IDX_W  = $clog2(CODE_W);

  cal_phase_e        phase;
  logic [IDX_W-1:0]  trial_idx;
  logic              start_evt;
  logic              eval_evt;
  logic              in_idle;
  logic [CODE_W-1:0] code;

  osc_cal_seq #(.CODE_W(CODE_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .phase_o    (phase),
    .idx_o      (trial_idx),
    .start_evt_o(start_evt),
    .eval_evt_o (eval_evt)
  );

  osc_cal_sar #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_sar (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .start_evt(start_evt),
    .eval_evt (eval_evt),
    .idx      (trial_idx),
    .slow_i   (slow_i),
    .code_o   (code)
  );

  assign in_idle = (phase == PH_IDLE);

  osc_cal_trim_hold #(.TRIM_W(TRIM_W)) u_trim (
    .clk    (clk),
    .rst_n  (rst_n),
    .capture(in_idle),
    .trim_i (trim_i),
    .trim_o (trim_o)
  );

  assign coarse_o = code[CODE_W-1:FINE_W];
  assign fine_o   = code[FINE_W-1:0];
  assign done_o   = (phase == PH_DONE);

endmodule

// File: rtl/osc_sar_cal_chk.sv
module osc_sar_cal_chk #(
  parameter int COARSE_W = 10,
  parameter int FINE_W   = 5,
  parameter int TRIM_W   = 8,
  localparam int CODE_W  = COARSE_W + FINE_W,
  localparam int IDX_W   = $clog2(CODE_W)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                enable,
  input logic                slow_i,
  input logic [TRIM_W-1:0]   trim_i,
  input logic [COARSE_W-1:0] coarse_o,
  input logic [FINE_W-1:0]   fine_o,
  input logic [TRIM_W-1:0]   trim_o,
  input logic                done_o,
  input logic                in_idle,
  input logic                eval_evt,
  input logic [IDX_W-1:0]    trial_idx
);

  localparam logic [COARSE_W-1:0] MID_C = COARSE_W'(1) << (COARSE_W - 1);
  localparam logic [FINE_W-1:0]   MID_F = FINE_W'(1) << (FINE_W - 1);
  localparam logic [CODE_W-1:0]   TOP_BIT = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] code_w;
  assign code_w = {coarse_o, fine_o};

  AST_PARK_MID: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!done_o && coarse_o == MID_C && fine_o == MID_F)); // R1

  AST_START_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && enable) |=> (code_w == TOP_BIT)); // R2

  AST_EVAL_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    eval_evt |=> !eval_evt); // R3

  AST_QUIET_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !in_idle && !eval_evt) |=> $stable(code_w)); // R3

  AST_DECISION_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    eval_evt |=> (code_w[$past(trial_idx)] == !$past(slow_i))); // R4

  AST_DONE_AFTER_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ($past(eval_evt) && $past(trial_idx) == '0)); // R6

  AST_FROZEN_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && enable) |=> (done_o && $stable(code_w))); // R7

  AST_TRIM_FOLLOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |=> (trim_o == $past(trim_i))); // R9

  AST_TRIM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_idle |=> $stable(trim_o)); // R9

endmodule

bind osc_sar_cal osc_sar_cal_chk #(
  .COARSE_W(COARSE_W),
  .FINE_W  (FINE_W),
  .TRIM_W  (TRIM_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .slow_i   (slow_i),
  .trim_i   (trim_i),
  .coarse_o (coarse_o),
  .fine_o   (fine_o),
  .trim_o   (trim_o),
  .done_o   (done_o),
  .in_idle  (in_idle),
  .eval_evt (eval_evt),
  .trial_idx(trial_idx)
);

// File: tb/tb_osc_sar_cal.sv
`timescale 1ns/1ps
module tb_osc_sar_cal;

  localparam int CW = 10;
  localparam int FW = 5;
  localparam int TW = 8;
  localparam int NB = CW + FW;
  localparam int MAXC = (1 << NB) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic          slow_i;
  logic [TW-1:0] trim_i = '0;
  logic [CW-1:0] coarse_o;
  logic [FW-1:0] fine_o;
  logic [TW-1:0] trim_o;
  logic          done_o;

  always #2.5 clk = ~clk;

  osc_sar_cal #(.COARSE_W(CW), .FINE_W(FW), .TRIM_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .slow_i(slow_i),
    .trim_i(trim_i), .coarse_o(coarse_o), .fine_o(fine_o),
    .trim_o(trim_o), .done_o(done_o)
  );

  // behavioural oscillator: period grows with the code
  longint base, slope, target;
  int     sh;
  bit     ovr_en = 1'b0, ovr_val = 1'b0;
  logic [NB-1:0] cur_code;
  longint cur_period;

  assign cur_code   = {coarse_o, fine_o};
  assign cur_period = base + longint'(cur_code) * slope
                    + ((longint'(cur_code) * longint'(cur_code)) >> sh);
  assign slow_i     = ovr_en ? ovr_val : (cur_period > target);

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  function automatic longint period_of(int c);
    return base + longint'(c) * slope + ((longint'(c) * longint'(c)) >> sh);
  endfunction

  function automatic int best_code();
    for (int c = MAXC; c >= 0; c--)
      if (period_of(c) <= target) return c;
    return 0;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_parked(string req);
    check(done_o == 1'b0, req, "done low when parked", done_o, 0);
    check(coarse_o == 10'd512 && fine_o == 5'd16, req, "mid-scale code",
          {coarse_o, fine_o}, {10'd512, 5'd16});
  endtask

  // full search; enable raised at a falling edge, edge 1 samples it
  task automatic run_cal(string tag);
    int rise = 0;
    bit two_in_row = 0, last_changed = 0, trim_moved = 0;
    logic [NB-1:0] prev;
    logic [TW-1:0] held;
    longint exp_first;
    int exp_final;
    exp_final = best_code();
    exp_first = (period_of(32'h4000) > target) ? 32'h2000 : 32'h6000;
    @(negedge clk);
    trim_i = TW'($urandom);
    held   = trim_i;
    enable = 1'b1;
    prev   = cur_code;
    for (int e = 1; e <= 33; e++) begin
      @(posedge clk); #1;
      if (cur_code != prev) begin
        if (last_changed) two_in_row = 1;
        last_changed = 1;
      end else last_changed = 0;
      prev = cur_code;
      if (e == 1) begin
        check(cur_code == 15'h4000, "R2", {tag, " first trial"}, cur_code, 15'h4000);
        trim_i = ~held;
      end
      if (e == 3)
        check(cur_code == exp_first, "R4", {tag, " top bit decision"}, cur_code, exp_first);
      if (e > 1 && trim_o != held) trim_moved = 1;
      if (done_o && rise == 0) rise = e;
    end
    check(rise == 31, "R6", {tag, " done edge"}, rise, 31);
    check(cur_code == exp_final, "R5", {tag, " final code"}, cur_code, exp_final);
    check(!two_in_row, "R3", {tag, " back-to-back code changes"}, two_in_row, 0);
    check(!trim_moved, "R9", {tag, " trim held"}, trim_o, held);
  endtask

  task automatic hold_test();
    logic [NB-1:0] kept;
    kept = cur_code;
    ovr_en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); ovr_val = k[0];
      @(posedge clk); #1;
    end
    check(cur_code == kept && done_o, "R7", "code frozen after done", cur_code, kept);
    ovr_en = 1'b0;
  endtask

  task automatic drop_enable();
    @(negedge clk); enable = 1'b0;
    @(posedge clk); #1;
    check_parked("R8");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    base = 1000; slope = 2; sh = 12; target = 0;
    repeat (3) @(posedge clk);
    #1;
    check_parked("R1");
    @(negedge clk); rst_n = 1'b1; trim_i = 8'hA5;
    @(posedge clk); #1;
    check_parked("R1");
    @(posedge clk); #1;
    check(trim_o == 8'hA5, "R9", "trim follows while idle", trim_o, 8'hA5);

    // nothing meets the target: all bits cleared
    target = 10;
    run_cal("none-fit"); hold_test(); drop_enable();
    // every code meets the target: all bits kept
    target = 64'd1 << 40;
    run_cal("all-fit"); drop_enable();
    // exact hit on a period value
    target = period_of(12345);
    run_cal("exact"); drop_enable();

    // abort midway, then restart
    target = period_of(777);
    @(negedge clk); enable = 1'b1;
    repeat (10) @(posedge clk);
    drop_enable();
    run_cal("restart"); hold_test(); drop_enable();

    for (int t = 0; t < 20; t++) begin
      base   = 500 + longint'($urandom_range(0, 5000));
      slope  = longint'($urandom_range(1, 6));
      sh     = $urandom_range(6, 20);
      target = period_of($urandom_range(0, MAXC)) + longint'($urandom_range(0, 3));
      run_cal("random");
      if (t % 4 == 0) hold_test();
      drop_enable();
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule